// File: doc/BRIEF.md
# Victim Buffer for a Direct-Mapped L1

The block is a small, fully associative store that sits beside a direct-mapped first-level cache and catches the blocks that L1 throws out. When L1 misses, the address is presented to this buffer before any request leaves for the next level. If the block is held here, it goes straight back to L1. The block that L1 displaces to make room is written into the entry that was just freed, in the same clock. A block therefore lives in L1 or in the buffer, never in both. The effect is that a few addresses fighting over one L1 set bounce between the two stores instead of going out to the next level each time.

The buffer has three ports. The insert port takes a block evicted from L1: its address, its data and its dirty flag. The lookup port takes a block address and answers combinationally in the same cycle with a hit flag, the block data and its dirty flag. That answer is the swap-out handed to L1, and the entry is released at the next clock edge. When the buffer is full, an insert replaces the entry that has been resident longest. If that entry is dirty, it appears on the write-back port one cycle later. The L1 arrays and the next-level memory are outside the block.

Top module: `victim_buffer`

## Requirements
- R1: After reset every entry is empty: any lookup misses and `wb_valid` is low.
- R2: With `lk_valid` high and an entry holding `lk_addr`, `lk_hit` is high in the same cycle and `lk_data` and `lk_dirty` carry that entry's data and dirty flag. With `lk_valid` low, `lk_hit` is low and the state is unchanged.
- R3: A lookup hit releases the entry at the next clock edge, so a following lookup of the same address misses.
- R4: A lookup hit together with an insert in the same cycle stores the inserted block in the released entry. The occupancy is unchanged and no write-back is produced.
- R5: An insert of a new address while an entry is free fills a free entry and produces no write-back.
- R6: An insert of a new address into a full buffer replaces the entry inserted earliest among those still resident. An entry released by a hit leaves this order.
- R7: When the replaced entry is dirty, `wb_valid` is high for the one cycle after the insert edge, with that entry's address on `wb_addr` and its data on `wb_data`. A clean replacement leaves `wb_valid` low.
- R8: An insert of an address already resident updates that entry's data, ORs its dirty flag with `ins_dirty`, keeps its place in the replacement order and creates no second entry.
- R9: No two valid entries ever hold the same address.
- R10: A block placed by a swap (R4) becomes the newest entry in the replacement order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ins_valid | input | 1 | A block evicted from L1 is presented for insertion |
| ins_addr | input | ADDR_W | Block address of the evicted block |
| ins_data | input | DATA_W | Data of the evicted block |
| ins_dirty | input | 1 | The evicted block is modified |
| lk_valid | input | 1 | Lookup request after an L1 miss |
| lk_addr | input | ADDR_W | Block address being looked up |
| lk_hit | output | 1 | The looked-up block is resident (same cycle) |
| lk_data | output | DATA_W | Data of the hit block, returned to L1; zero on a miss |
| lk_dirty | output | 1 | Dirty flag of the hit block |
| wb_valid | output | 1 | A dirty block was replaced and must be written to the next level |
| wb_addr | output | ADDR_W | Address of the written-back block |
| wb_data | output | DATA_W | Data of the written-back block |

## Verification
A corrupted replacement order stays hidden until the buffer is full. It then shows up as the wrong address on `wb_addr`, or as a missing write-back, on the insert that should have pushed out a dirty block. The bench therefore fills the buffer and cycles through it with a mix of hits, swaps and merges. A stale valid flag shows up on the very next lookup of the released address, as a hit where a miss was expected. A duplicated entry would stay invisible at the ports until one copy was released and the other still answered, so it is also watched on every cycle by a pairwise comparison of the resident addresses.

// File: rtl/vb_pkg.sv
package vb_pkg;
  // Kind of write an insert request performs on the entry array
  typedef enum logic [2:0] {
    PUT_NONE,
    PUT_MERGE,   // address already resident: refresh data, OR dirty
    PUT_SWAP,    // refill the entry released by a same-cycle lookup hit
    PUT_FILL,    // take a free entry
    PUT_EVICT    // replace the earliest-inserted entry
  } put_kind_e;
endpackage

// File: rtl/vb_match.sv
module vb_match #(
  parameter int N  = 4,
  parameter int AW = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]         vld,
  input  logic [N-1:0]         excl,
  input  logic [N-1:0][AW-1:0] tags,
  input  logic [AW-1:0]        key,
  output logic                 any,
  output logic [IDX_W-1:0]     idx
);
  logic [N-1:0] eq;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = vld[g] & ~excl[g] & (tags[g] == key);
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (eq[i]) idx = IDX_W'(i);
    end
  end

  assign any = |eq;
endmodule

// File: rtl/vb_order.sv
// Insertion-order tracker: valid entries hold distinct ranks 0..k-1,
// rank 0 is the newest, rank N-1 marks the oldest of a full buffer.
module vb_order #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     vld,
  input  logic             put_en,
  input  logic [IDX_W-1:0] put_idx,
  input  logic             drop_en,
  input  logic [IDX_W-1:0] drop_idx,
  output logic [IDX_W-1:0] oldest_idx
);
  logic [N-1:0][IDX_W-1:0] rank_q, rank_n;
  logic [IDX_W:0]          ref_rank;

  always_comb begin
    rank_n   = rank_q;
    ref_rank = vld[put_idx] ? {1'b0, rank_q[put_idx]} : (IDX_W+1)'(N);
    for (int i = 0; i < N; i++) begin
      if (put_en) begin
        if (put_idx == IDX_W'(i)) rank_n[i] = '0;
        else if (vld[i] && ({1'b0, rank_q[i]} < ref_rank)) rank_n[i] = rank_q[i] + 1'b1;
      end else if (drop_en && vld[i] && (rank_q[i] > rank_q[drop_idx])) begin
        rank_n[i] = rank_q[i] - 1'b1;
      end
    end
  end

  always_comb begin
    oldest_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (vld[i] && (rank_q[i] == IDX_W'(N - 1))) oldest_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rank_q <= '0;
    else if (put_en | drop_en) rank_q <= rank_n;
  end
endmodule

// File: rtl/victim_buffer.sv
module victim_buffer #(
  parameter int NUM_ENTRIES = 4,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [DATA_W-1:0] ins_data,
  input  logic              ins_dirty,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  output logic              lk_dirty,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data
);
  import vb_pkg::*;
  localparam int N = NUM_ENTRIES;

  logic [N-1:0]             vld_q, vld_n, dirty_q, dirty_n;
  logic [N-1:0][ADDR_W-1:0] tag_q;
  logic [N-1:0][DATA_W-1:0] data_q;
  logic                     wb_valid_q, wb_valid_n;
  logic [ADDR_W-1:0]        wb_addr_q;
  logic [DATA_W-1:0]        wb_data_q;

  logic                     lk_any, in_any, full, put_en, drop_en;
  logic [IDX_W-1:0]         lk_idx, in_idx, free_idx, oldest_idx, put_idx;
  logic [N-1:0]             swap_mask;
  put_kind_e                put_kind;

  // Parallel compare for the lookup, and for the insert with the
  // entry being released this cycle masked out
  vb_match #(.N(N), .AW(ADDR_W)) u_lk_match (
    .vld(vld_q), .excl('0), .tags(tag_q), .key(lk_addr), .any(lk_any), .idx(lk_idx));

  assign lk_hit    = lk_valid & lk_any;
  assign swap_mask = {N{lk_hit}} & (N'(1) << lk_idx);

  vb_match #(.N(N), .AW(ADDR_W)) u_in_match (
    .vld(vld_q), .excl(swap_mask), .tags(tag_q), .key(ins_addr), .any(in_any), .idx(in_idx));

  assign lk_data  = lk_hit ? data_q[lk_idx] : '0;
  assign lk_dirty = lk_hit & dirty_q[lk_idx];
  assign full     = &vld_q;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld_q[i]) free_idx = IDX_W'(i);
    end
  end

  // Choose what the insert does and where it lands
  always_comb begin
    put_kind = PUT_NONE;
    put_idx  = '0;
    if (ins_valid) begin
      if (in_any)      begin put_kind = PUT_MERGE; put_idx = in_idx;     end
      else if (lk_hit) begin put_kind = PUT_SWAP;  put_idx = lk_idx;     end
      else if (!full)  begin put_kind = PUT_FILL;  put_idx = free_idx;   end
      else             begin put_kind = PUT_EVICT; put_idx = oldest_idx; end
    end
  end

  assign put_en  = (put_kind != PUT_NONE) && (put_kind != PUT_MERGE);
  assign drop_en = lk_hit && (put_kind != PUT_SWAP);

  vb_order #(.N(N)) u_order (
    .clk(clk), .rst_n(rst_n), .vld(vld_q),
    .put_en(put_en), .put_idx(put_idx),
    .drop_en(drop_en), .drop_idx(lk_idx),
    .oldest_idx(oldest_idx));

  // Next state of flags
  always_comb begin
    vld_n      = vld_q;
    dirty_n    = dirty_q;
    wb_valid_n = (put_kind == PUT_EVICT) && dirty_q[put_idx];
    if (lk_hit) vld_n[lk_idx] = 1'b0;
    if (put_kind == PUT_MERGE) begin
      dirty_n[put_idx] = dirty_q[put_idx] | ins_dirty;
    end else if (put_en) begin
      vld_n[put_idx]   = 1'b1;
      dirty_n[put_idx] = ins_dirty;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q      <= '0;
      dirty_q    <= '0;
      wb_valid_q <= 1'b0;
    end else begin
      vld_q      <= vld_n;
      dirty_q    <= dirty_n;
      wb_valid_q <= wb_valid_n;
    end
  end

  // Payload registers, written only under their enables
  always_ff @(posedge clk) begin
    if (put_kind != PUT_NONE) begin
      tag_q[put_idx]  <= ins_addr;
      data_q[put_idx] <= ins_data;
    end
    if (wb_valid_n) begin
      wb_addr_q <= tag_q[put_idx];
      wb_data_q <= data_q[put_idx];
    end
  end

  assign wb_valid = wb_valid_q;
  assign wb_addr  = wb_addr_q;
  assign wb_data  = wb_data_q;
endmodule

// File: rtl/vb_checker.sv
module vb_checker #(
  parameter int N  = 4,
  parameter int AW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N-1:0]         vld,
  input logic [N-1:0][AW-1:0] tags,
  input logic                 ins_valid,
  input logic [AW-1:0]        ins_addr,
  input logic                 lk_hit,
  input logic [AW-1:0]        lk_addr,
  input logic                 wb_valid
);
  logic [AW-1:0] ins_addr_d, lk_addr_d;
  logic [N-1:0]  has_ins, has_lk;

  always_ff @(posedge clk) begin
    ins_addr_d <= ins_addr;
    lk_addr_d  <= lk_addr;
  end

  for (genvar g = 0; g < N; g++) begin : g_res
    assign has_ins[g] = vld[g] && (tags[g] == ins_addr_d);
    assign has_lk[g]  = vld[g] && (tags[g] == lk_addr_d);
  end

  // R9: no address is held by two valid entries
  for (genvar a = 0; a < N; a++) begin : g_pa
    for (genvar b = a + 1; b < N; b++) begin : g_pb
      p_unique_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(vld[a] && vld[b] && (tags[a] == tags[b])));
    end
  end

  // R5/R8: an inserted address is resident after the edge
  p_insert_resident_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |=> (|has_ins));

  // R3: a hit address is gone after the edge unless re-inserted
  p_hit_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && !(ins_valid && (ins_addr == lk_addr))) |=> !(|has_lk));

  // R7: a write-back only follows an insert
  p_wb_follows_insert_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(ins_valid));
endmodule

bind victim_buffer vb_checker #(.N(NUM_ENTRIES), .AW(ADDR_W)) u_vb_checker (
  .clk(clk), .rst_n(rst_n), .vld(vld_q), .tags(tag_q),
  .ins_valid(ins_valid), .ins_addr(ins_addr),
  .lk_hit(lk_hit), .lk_addr(lk_addr), .wb_valid(wb_valid));

// File: tb/victim_buffer_tb.sv
`timescale 1ns/1ps
module victim_buffer_tb;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ins_valid, ins_dirty, lk_valid;
  logic [AW-1:0] ins_addr, lk_addr;
  logic [DW-1:0] ins_data;
  logic          lk_hit, lk_dirty, wb_valid;
  logic [DW-1:0] lk_data, wb_data;
  logic [AW-1:0] wb_addr;

  int checks   = 0;
  int failures = 0;

  always #2 clk = ~clk;

  victim_buffer #(.NUM_ENTRIES(4), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_addr(ins_addr), .ins_data(ins_data), .ins_dirty(ins_dirty),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_data(lk_data), .lk_dirty(lk_dirty),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data));

  function automatic logic [DW-1:0] dpat(input logic [AW-1:0] a);
    return {~a, a};
  endfunction

  typedef struct packed {
    logic          iv;
    logic [AW-1:0] ia;
    logic [DW-1:0] idt;
    logic          idr;
    logic          lv;
    logic [AW-1:0] la;
    logic          eh;
    logic          edr;
    logic          ew;
    logic [AW-1:0] ewa;
    logic [DW-1:0] ewd;
  } vec_t;

  function automatic vec_t v(input logic iv, input logic [AW-1:0] ia, input logic [DW-1:0] idt,
                             input logic idr, input logic lv, input logic [AW-1:0] la,
                             input logic eh, input logic edr, input logic ew,
                             input logic [AW-1:0] ewa, input logic [DW-1:0] ewd);
    vec_t r;
    r.iv = iv; r.ia = ia; r.idt = idt; r.idr = idr; r.lv = lv; r.la = la;
    r.eh = eh; r.edr = edr; r.ew = ew; r.ewa = ewa; r.ewd = ewd;
    return r;
  endfunction

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    v(1, 16'h10, dpat(16'h10), 0, 0, 16'h10, 0, 0, 0, 0, 0),           // R5 fill
    v(1, 16'h11, dpat(16'h11), 1, 0, 16'h00, 0, 0, 0, 0, 0),           // R5
    v(1, 16'h12, dpat(16'h12), 0, 0, 16'h00, 0, 0, 0, 0, 0),           // R5
    v(1, 16'h13, dpat(16'h13), 1, 0, 16'h00, 0, 0, 0, 0, 0),           // R5 now full
    v(0, 16'h00, 0,            0, 1, 16'h11, 1, 1, 0, 0, 0),           // R2 hit
    v(0, 16'h00, 0,            0, 1, 16'h11, 0, 0, 0, 0, 0),           // R3 released
    v(1, 16'h14, dpat(16'h14), 0, 0, 16'h00, 0, 0, 0, 0, 0),           // R5 refill hole
    v(1, 16'h15, dpat(16'h15), 1, 0, 16'h00, 0, 0, 0, 0, 0),           // R6 evict 0x10 clean
    v(1, 16'h16, dpat(16'h16), 0, 0, 16'h00, 0, 0, 0, 0, 0),           // R6 evict 0x12 clean
    v(1, 16'h17, dpat(16'h17), 0, 0, 16'h00, 0, 0, 1, 16'h13, dpat(16'h13)), // R7 evict dirty 0x13
    v(1, 16'h20, dpat(16'h20), 1, 1, 16'h15, 1, 1, 0, 0, 0),           // R4 swap
    v(0, 16'h00, 0,            0, 1, 16'h15, 0, 0, 0, 0, 0),           // R4 swapped out
    v(1, 16'h14, 32'h1234_5678, 1, 0, 16'h00, 0, 0, 0, 0, 0),          // R8 merge
    v(1, 16'h21, dpat(16'h21), 0, 0, 16'h00, 0, 0, 1, 16'h14, 32'h1234_5678), // R8 kept oldest, now dirty
    v(1, 16'h22, dpat(16'h22), 1, 0, 16'h00, 0, 0, 0, 0, 0),           // R6 evict 0x16
    v(1, 16'h23, dpat(16'h23), 0, 0, 16'h00, 0, 0, 0, 0, 0),           // R6 evict 0x17
    v(1, 16'h24, dpat(16'h24), 0, 0, 16'h00, 0, 0, 1, 16'h20, dpat(16'h20)), // R10 swap-in aged last
    v(0, 16'h00, 0,            0, 1, 16'h22, 1, 1, 0, 0, 0),           // R2
    v(0, 16'h00, 0,            0, 0, 16'h23, 0, 0, 0, 0, 0),           // R2 idle lookup
    v(0, 16'h00, 0,            0, 1, 16'h23, 1, 0, 0, 0, 0)            // R2 idle left it resident
  };

  task automatic check(input string req, input int step, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s step %0d: actual=%h expected=%h", req, step, act, exp);
    end
  endtask

  // Drive at a falling edge, check the same-cycle lookup answer, then
  // check the registered write-back at the next falling edge.
  task automatic step(input int idx, input vec_t t);
    ins_valid = t.iv; ins_addr = t.ia; ins_data = t.idt; ins_dirty = t.idr;
    lk_valid  = t.lv; lk_addr  = t.la;
    #1;
    check("R2 lk_hit", idx, DW'(lk_hit), DW'(t.eh));
    if (t.eh) begin
      check("R2 lk_data", idx, lk_data, dpat(t.la));
      check("R2 lk_dirty", idx, DW'(lk_dirty), DW'(t.edr));
    end
    @(negedge clk);
    ins_valid = 1'b0; lk_valid = 1'b0;
    check("R7 wb_valid", idx, DW'(wb_valid), DW'(t.ew));
    if (t.ew) begin
      check("R6 wb_addr", idx, DW'(wb_addr), DW'(t.ewa));
      check("R7 wb_data", idx, wb_data, t.ewd);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    ins_valid = 1'b0; ins_addr = '0; ins_data = '0; ins_dirty = 1'b0;
    lk_valid = 1'b0; lk_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: empty after reset
    step(100, v(0, 0, 0, 0, 1, 16'h10, 0, 0, 0, 0, 0));

    for (int i = 0; i < NV; i++) step(i, VECS[i]);

    // R1: reset in the middle of operation empties the buffer
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    step(200, v(0, 0, 0, 0, 1, 16'h21, 0, 0, 0, 0, 0));
    step(201, v(0, 0, 0, 0, 1, 16'h24, 0, 0, 0, 0, 0));

    // R8/R9: inserting one address twice leaves a single, merged copy
    step(300, v(1, 16'h30, 32'hAAAA_0000, 0, 0, 0, 0, 0, 0, 0, 0));
    step(301, v(1, 16'h30, dpat(16'h30), 1, 0, 0, 0, 0, 0, 0, 0));
    step(302, v(0, 0, 0, 0, 1, 16'h30, 1, 1, 0, 0, 0));
    step(303, v(0, 0, 0, 0, 1, 16'h30, 0, 0, 0, 0, 0));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #40000;
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule